// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Matcher

This block sits beside one interrupt-controller unit in a multi-unit system. It decides whether an interprocessor interrupt command is aimed at this unit. The command is 64 bits wide and arrives as a high word and a low word. The high word carries the 8-bit destination. The low word carries the vector, delivery mode, destination mode, level, trigger and shorthand fields.

The block also holds the unit's physical ID, its logical ID and its destination format register. These are written through a small register-select port and can be read back on a separate select port.

Writing the low word starts an evaluation. One cycle later, the block raises a single-cycle valid pulse. With that pulse it presents a match flag, an error flag and the decoded fields. An input tells the block whether the command was issued by this same unit, which the self-related shorthands need. Choosing one target among several units for lowest-priority delivery is left to logic outside this block, and so is the delivery itself.

Top module: `ipi_target_match`

## Requirements
- R1: After reset the register-select encodings read as follows: 0 is the physical ID, 1 is the logical ID, 2 is the format register, 3 is the command low word and 4 is the command high word. After reset, select 0 reads {UNIT_INDEX, 24'h0}, select 2 reads 32'hFFFF_FFFF, and selects 1, 3 and 4 read zero. No valid pulse occurs during or right after reset.
- R2: A write of the command low word stores the data with bit 12 forced to zero. A write of the high word keeps only bits 31:24, which form the destination; the other bits read back as zero.
- R3: Each low-word write produces a valid pulse exactly one cycle later, lasting exactly one cycle. Writes to any other select produce no pulse.
- R4: The decoded outputs follow the low-word layout: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11 (1 means logical), level in bit 14, trigger in bit 15 and shorthand in bits 19:18.
- R5: Shorthand 1 matches only when the command came from this unit. Shorthand 2 always matches. Shorthand 3 matches only when the command came from another unit.
- R6: With shorthand 0 and physical mode, the block matches when the destination equals the physical ID held in bits 31:24 of select 0. A write to select 0 keeps only those bits.
- R7: With shorthand 0, logical mode and format bits 31:28 all ones (flat), the block matches when the logical ID (bits 31:24 of select 1) ANDed with the destination is nonzero. A write to select 1 keeps only bits 31:24.
- R8: With shorthand 0, logical mode and any other format value (cluster), the block matches when two conditions both hold: the high nibbles of the logical ID and of the destination are equal, and their low nibbles AND to a nonzero value.
- R9: In cluster mode, delivery mode 1 (lowest priority) with destination 8'hFF raises the error flag and gives no match. The error flag stays clear in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select for the write |
| wrData | input | 32 | Write data |
| fromSelf | input | 1 | The command being written was issued by this unit |
| rdSel | input | 3 | Register select for read-back |
| rdData | output | 32 | Read-back data |
| resValid | output | 1 | One-cycle pulse marking a fresh result |
| resMatch | output | 1 | This unit is a target |
| resError | output | 1 | Illegal lowest-priority broadcast in cluster mode |
| resVector | output | 8 | Decoded vector |
| resDelivMode | output | 3 | Decoded delivery mode |
| resDestLogical | output | 1 | Decoded destination mode (1 = logical) |
| resLevel | output | 1 | Decoded assert level |
| resTrigger | output | 1 | Decoded trigger mode |
| resShorthand | output | 2 | Decoded shorthand |

## Verification
The bench targets the self-related shorthands with the sender flag both set and clear. A design that inverts the exclude-self case would claim broadcasts it sent itself.

Cluster destinations are chosen so that the cluster nibbles match while the member nibbles do not, and the reverse. A design that only ANDs the full byte would wrongly accept these.

A lowest-priority broadcast is sent once under the flat format and once under the cluster format. A design that flags the error under both formats would miss a legal flat broadcast.

Read-back after low-word writes with bit 12 set exposes a design that stores the pending bit. A high-word write that is followed by no pulse exposes a design that evaluates on the wrong word.

// File: rtl/ipi_match_pkg.sv
package ipi_match_pkg;

  typedef enum logic [2:0] {
    SEL_PHYS_ID = 3'd0,
    SEL_LOG_ID  = 3'd1,
    SEL_FORMAT  = 3'd2,
    SEL_CMD_LO  = 3'd3,
    SEL_CMD_HI  = 3'd4
  } regSel_e;

  // Load strobes from control to datapath
  typedef struct packed {
    logic ldPhys;
    logic ldLog;
    logic ldFmt;
    logic ldLo;
    logic ldHi;
  } strobes_t;

  localparam logic [2:0] DM_LOWEST = 3'd1;

  localparam logic [1:0] SH_NONE     = 2'd0;
  localparam logic [1:0] SH_SELF     = 2'd1;
  localparam logic [1:0] SH_ALL      = 2'd2;
  localparam logic [1:0] SH_ALL_BUT  = 2'd3;

endpackage

// File: rtl/ipi_match_ctrl.sv
module ipi_match_ctrl
  import ipi_match_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  output strobes_t         strb,
  output logic             resValid
);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (wrSel)
        SEL_PHYS_ID: strb.ldPhys = 1'b1;
        SEL_LOG_ID:  strb.ldLog  = 1'b1;
        SEL_FORMAT:  strb.ldFmt  = 1'b1;
        SEL_CMD_LO:  strb.ldLo   = 1'b1;
        SEL_CMD_HI:  strb.ldHi   = 1'b1;
        default:     strb        = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resValid <= 1'b0;
    else        resValid <= strb.ldLo;
  end

  // R3
  validAfterLo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrSel == SEL_CMD_LO) |=> resValid);

  // R3
  noValidOtherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && wrSel == SEL_CMD_LO) |=> !resValid);

endmodule

// File: rtl/ipi_match_datapath.sv
module ipi_match_datapath
  import ipi_match_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ID_W       = 8,
  parameter int              SEL_W      = 3,
  parameter logic [ID_W-1:0] UNIT_INDEX = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fromSelf,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              resMatch,
  output logic              resError,
  output logic [7:0]        resVector,
  output logic [2:0]        resDelivMode,
  output logic              resDestLogical,
  output logic              resLevel,
  output logic              resTrigger,
  output logic [1:0]        resShorthand
);

  localparam int ID_LSB   = DATA_W - ID_W;
  localparam int NIB_W    = ID_W / 2;
  localparam int FMT_W    = 4;
  localparam int PEND_BIT = 12;
  localparam int VEC_LSB  = 0;
  localparam int DM_LSB   = 8;
  localparam int DMODE_B  = 11;
  localparam int LVL_B    = 14;
  localparam int TRG_B    = 15;
  localparam int SH_LSB   = 18;

  logic [ID_W-1:0]   physIdQ;
  logic [ID_W-1:0]   logIdQ;
  logic [DATA_W-1:0] fmtQ;
  logic [DATA_W-1:0] cmdLoQ;
  logic [ID_W-1:0]   destQ;

  logic [DATA_W-1:0] loNext;
  logic [1:0]        shNext;
  logic [2:0]        dmNext;
  logic              logicalNext;
  logic              flatFmt;
  logic              physHit, flatHit, clusterHit, lowestBcast;
  logic              matchNext, errorNext;

  // Register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      physIdQ <= UNIT_INDEX;
      logIdQ  <= '0;
      fmtQ    <= '1;
      cmdLoQ  <= '0;
      destQ   <= '0;
    end else begin
      if (strb.ldPhys) physIdQ <= wrData[DATA_W-1:ID_LSB];
      if (strb.ldLog)  logIdQ  <= wrData[DATA_W-1:ID_LSB];
      if (strb.ldFmt)  fmtQ    <= wrData;
      if (strb.ldLo)   cmdLoQ  <= loNext;
      if (strb.ldHi)   destQ   <= wrData[DATA_W-1:ID_LSB];
    end
  end

  // Destination decision on the incoming low word
  always_comb begin
    loNext           = wrData;
    loNext[PEND_BIT] = 1'b0;
  end

  assign shNext      = loNext[SH_LSB +: 2];
  assign dmNext      = loNext[DM_LSB +: 3];
  assign logicalNext = loNext[DMODE_B];
  assign flatFmt     = (fmtQ[DATA_W-1 -: FMT_W] == {FMT_W{1'b1}});
  assign physHit     = (destQ == physIdQ);
  assign flatHit     = |(logIdQ & destQ);
  assign clusterHit  = (logIdQ[ID_W-1 -: NIB_W] == destQ[ID_W-1 -: NIB_W]) &&
                       (|(logIdQ[NIB_W-1:0] & destQ[NIB_W-1:0]));
  assign lowestBcast = (dmNext == DM_LOWEST) && (destQ == {ID_W{1'b1}});

  always_comb begin
    matchNext = 1'b0;
    errorNext = 1'b0;
    case (shNext)
      SH_SELF:    matchNext = fromSelf;
      SH_ALL:     matchNext = 1'b1;
      SH_ALL_BUT: matchNext = !fromSelf;
      default: begin
        if (!logicalNext)      matchNext = physHit;
        else if (flatFmt)      matchNext = flatHit;
        else if (lowestBcast)  errorNext = 1'b1;
        else                   matchNext = clusterHit;
      end
    endcase
  end

  // Result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resMatch       <= 1'b0;
      resError       <= 1'b0;
      resVector      <= '0;
      resDelivMode   <= '0;
      resDestLogical <= 1'b0;
      resLevel       <= 1'b0;
      resTrigger     <= 1'b0;
      resShorthand   <= '0;
    end else if (strb.ldLo) begin
      resMatch       <= matchNext;
      resError       <= errorNext;
      resVector      <= loNext[VEC_LSB +: 8];
      resDelivMode   <= dmNext;
      resDestLogical <= logicalNext;
      resLevel       <= loNext[LVL_B];
      resTrigger     <= loNext[TRG_B];
      resShorthand   <= shNext;
    end
  end

  // Read-back
  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_PHYS_ID: rdData[DATA_W-1:ID_LSB] = physIdQ;
      SEL_LOG_ID:  rdData[DATA_W-1:ID_LSB] = logIdQ;
      SEL_FORMAT:  rdData = fmtQ;
      SEL_CMD_LO:  rdData = cmdLoQ;
      SEL_CMD_HI:  rdData[DATA_W-1:ID_LSB] = destQ;
      default:     rdData = '0;
    endcase
  end

  // R2
  pendingCleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ldLo |=> (cmdLoQ[PEND_BIT] == 1'b0) &&
                  (cmdLoQ[PEND_BIT-1:0] == $past(wrData[PEND_BIT-1:0])));

  // R5
  broadcastAll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ldLo && wrData[SH_LSB +: 2] == SH_ALL) |=> resMatch);

  // R5
  excludeSelf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ldLo && wrData[SH_LSB +: 2] == SH_ALL_BUT && fromSelf) |=> !resMatch);

  // R6
  physEqual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ldLo && wrData[SH_LSB +: 2] == SH_NONE && !wrData[DMODE_B] &&
     destQ == physIdQ) |=> resMatch);

  // R9
  errorNoMatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resError |-> !resMatch);

endmodule

// File: rtl/ipi_target_match.sv
module ipi_target_match
  import ipi_match_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ID_W       = 8,
  parameter int              SEL_W      = 3,
  parameter logic [ID_W-1:0] UNIT_INDEX = 8'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fromSelf,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              resValid,
  output logic              resMatch,
  output logic              resError,
  output logic [7:0]        resVector,
  output logic [2:0]        resDelivMode,
  output logic              resDestLogical,
  output logic              resLevel,
  output logic              resTrigger,
  output logic [1:0]        resShorthand
);

  strobes_t strb;

  ipi_match_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .strb     (strb),
    .resValid (resValid)
  );

  ipi_match_datapath #(
    .DATA_W     (DATA_W),
    .ID_W       (ID_W),
    .SEL_W      (SEL_W),
    .UNIT_INDEX (UNIT_INDEX)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strb           (strb),
    .wrData         (wrData),
    .fromSelf       (fromSelf),
    .rdSel          (rdSel),
    .rdData         (rdData),
    .resMatch       (resMatch),
    .resError       (resError),
    .resVector      (resVector),
    .resDelivMode   (resDelivMode),
    .resDestLogical (resDestLogical),
    .resLevel       (resLevel),
    .resTrigger     (resTrigger),
    .resShorthand   (resShorthand)
  );

endmodule

// File: tb/ipi_target_match_tb.sv
`timescale 1ns/100ps
module ipi_target_match_tb;

  localparam logic [7:0] UNIT = 8'd3;

  typedef struct packed {
    logic       match;
    logic       err;
    logic [7:0] vec;
    logic [2:0] dm;
    logic       logical;
    logic       lvl;
    logic       trg;
    logic [1:0] sh;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic        fromSelf = 1'b0;
  logic [2:0]  rdSel = '0;
  logic [31:0] rdData;
  logic        resValid, resMatch, resError, resDestLogical, resLevel, resTrigger;
  logic [7:0]  resVector;
  logic [2:0]  resDelivMode;
  logic [1:0]  resShorthand;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int loWrites = 0;
  bit done = 1'b0;

  exp_t  expQ[$];
  string tagQ[$];

  // Bench shadow of stored state
  logic [7:0]  shPhys = UNIT;
  logic [7:0]  shLog = 8'h00;
  logic [31:0] shFmt = 32'hFFFF_FFFF;
  logic [7:0]  shDest = 8'h00;

  always #2.5 clk = ~clk;

  ipi_target_match #(.UNIT_INDEX(UNIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .fromSelf(fromSelf), .rdSel(rdSel), .rdData(rdData), .resValid(resValid),
    .resMatch(resMatch), .resError(resError), .resVector(resVector),
    .resDelivMode(resDelivMode), .resDestLogical(resDestLogical),
    .resLevel(resLevel), .resTrigger(resTrigger), .resShorthand(resShorthand)
  );

  function automatic exp_t model(input logic [31:0] lo, input logic self);
    exp_t e;
    e = '0;
    e.vec = lo[7:0]; e.dm = lo[10:8]; e.logical = lo[11];
    e.lvl = lo[14]; e.trg = lo[15]; e.sh = lo[19:18];
    case (e.sh)
      2'd1: e.match = self;
      2'd2: e.match = 1'b1;
      2'd3: e.match = !self;
      default: begin
        if (!e.logical) e.match = (shDest == shPhys);
        else if (shFmt[31:28] == 4'hF) e.match = |(shLog & shDest);
        else if (e.dm == 3'd1 && shDest == 8'hFF) e.err = 1'b1;
        else e.match = (shLog[7:4] == shDest[7:4]) && |(shLog[3:0] & shDest[3:0]);
      end
    endcase
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    case (sel)
      3'd0: shPhys = d[31:24];
      3'd1: shLog  = d[31:24];
      3'd2: shFmt  = d;
      3'd4: shDest = d[31:24];
      default: ;
    endcase
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendCmd(input logic [31:0] lo, input logic self, input string tag);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'd3; wrData = lo; fromSelf = self;
    expQ.push_back(model(lo, self));
    tagQ.push_back(tag);
    loWrites++;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [2:0] sel, input logic [31:0] exp,
                           input string tag);
    rdSel = sel;
    #1;
    check(rdData === exp, tag, {32'h0, rdData}, {32'h0, exp});
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && resValid) begin
      exp_t act;
      exp_t e;
      string t;
      pulses++;
      act = {resMatch, resError, resVector, resDelivMode, resDestLogical,
             resLevel, resTrigger, resShorthand};
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected pulse", {46'h0, act}, 64'h0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(act === e, t, {46'h0, act}, {46'h0, e});
      end
    end
  end

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(resValid === 1'b0, "R1 no pulse in reset", {63'h0, resValid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(resValid === 1'b0, "R1 no pulse after reset", {63'h0, resValid}, 64'h0);
    readCheck(3'd0, {UNIT, 24'h0}, "R1 physical id");
    readCheck(3'd1, 32'h0, "R1 logical id");
    readCheck(3'd2, 32'hFFFF_FFFF, "R1 format");
    readCheck(3'd3, 32'h0, "R1 low word");
    readCheck(3'd4, 32'h0, "R1 high word");

    // R2 high word keeps only destination; no pulse (R3)
    writeReg(3'd4, 32'h03AB_CDEF);
    check(resValid === 1'b0, "R3 no pulse on high write", {63'h0, resValid}, 64'h0);
    readCheck(3'd4, 32'h0300_0000, "R2 high word mask");

    // R6 physical match, R4 fields, R2 pending bit
    sendCmd(32'h0000_D641, 1'b0, "R6 R4 physical hit");
    readCheck(3'd3, 32'h0000_C641, "R2 pending bit cleared");
    writeReg(3'd4, 32'h0400_0000);
    sendCmd(32'h0000_1022, 1'b0, "R6 physical miss");
    writeReg(3'd0, 32'h0412_3456);
    readCheck(3'd0, 32'h0400_0000, "R6 id mask");
    sendCmd(32'h0000_0033, 1'b0, "R6 physical new id");

    // R5 shorthands
    sendCmd(32'h0004_4050, 1'b1, "R5 self from self");
    sendCmd(32'h0004_4050, 1'b0, "R5 self from other");
    sendCmd(32'h0008_8160, 1'b0, "R5 all");
    sendCmd(32'h000C_0270, 1'b1, "R5 all-but from self");
    sendCmd(32'h000C_0270, 1'b0, "R5 all-but from other");

    // R7 flat logical
    writeReg(3'd1, 32'h24FF_FFFF);
    readCheck(3'd1, 32'h2400_0000, "R7 logical id mask");
    writeReg(3'd4, 32'h0400_0000);
    sendCmd(32'h0000_0880, 1'b0, "R7 flat hit");
    writeReg(3'd4, 32'h8000_0000);
    sendCmd(32'h0000_0881, 1'b0, "R7 flat miss");
    writeReg(3'd4, 32'hFF00_0000);
    sendCmd(32'h0000_0990, 1'b0, "R9 flat lowest broadcast legal");

    // R8 cluster logical
    writeReg(3'd2, 32'h0FFF_FFFF);
    readCheck(3'd2, 32'h0FFF_FFFF, "R8 format readback");
    writeReg(3'd4, 32'h2600_0000);
    sendCmd(32'h0000_08A0, 1'b0, "R8 cluster hit");
    writeReg(3'd4, 32'h3400_0000);
    sendCmd(32'h0000_08A1, 1'b0, "R8 cluster mismatch");
    writeReg(3'd4, 32'h2100_0000);
    sendCmd(32'h0000_08A2, 1'b0, "R8 member miss");

    // R9 cluster lowest broadcast error
    writeReg(3'd4, 32'hFF00_0000);
    sendCmd(32'h0000_09B0, 1'b0, "R9 cluster lowest error");
    sendCmd(32'h0000_08B1, 1'b0, "R9 cluster fixed broadcast");

    repeat (3) @(negedge clk);
    check(pulses == loWrites, "R3 pulse count", 64'(pulses), 64'(loWrites));
    check(expQ.size() == 0, "R3 queue drained", 64'(expQ.size()), 64'h0);
    finishRun();
  end

endmodule